// File: doc/BRIEF.md
# Segmented Address Translator with Access Protection

This block turns a logical address, made of a segment number and an offset within that segment, into a physical address. It holds a table of per-segment descriptors. Each descriptor has a physical start address, a segment length, a presence flag and three access rights: read, write and execute. A separate bound register says how many segments are currently in use. Segment numbers at or above that bound are illegal.

Before it relocates an address, the block runs four checks in a fixed order. The segment number must be in range. The descriptor must be present. The offset must be inside the segment. The access kind must be allowed. If any check fails, the response is a fault with a cause code. If all checks pass, the response is the start address plus the offset. A single configuration write port loads descriptors and the bound register. A request is accepted on any cycle and answered exactly one cycle later.

Top module: `seg_xlate_top`

## Requirements
- R1: Each cycle with `req_valid` high gives exactly one cycle of `rsp_valid` high on the following cycle. When `rsp_valid` is low, `rsp_fault` is 0 and `rsp_cause` is 0.
- R2: A configuration write with `cfg_sel`=0 loads the descriptor at `cfg_idx` from `cfg_base`, `cfg_limit` and `cfg_flags`. A write with `cfg_sel`=1 loads the bound register from `cfg_len`. A request in the same cycle as a write sees the old contents. Requests from the next cycle on see the new contents.
- R3: A request whose segment number is greater than or equal to the bound register faults with cause 1 (range).
- R4: A request to an in-range segment whose descriptor has `cfg_flags` bit 3 (present) clear faults with cause 2 (absent).
- R5: For a present, in-range descriptor, an offset greater than or equal to its length faults with cause 3 (bounds). A length of 0 therefore faults on every offset.
- R6: Access kind codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. The matching right is flag bit 2 for read, bit 1 for write and bit 0 for execute. When the matching right is clear, the request faults with cause 4 (rights). Kind 3 always faults with cause 4.
- R7: When several checks fail, only one cause is reported, in this precedence: range (1), absent (2), bounds (3), rights (4). `rsp_fault` is 1 exactly when `rsp_cause` is non-zero.
- R8: A request that passes every check returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = (start + offset) modulo 2^24.
- R9: Every faulting response drives `rsp_paddr` to 0.
- R10: After reset, the bound register is 0, every descriptor is absent, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 descriptor, 1 bound register |
| cfg_idx | input | 4 | Descriptor index for a descriptor write |
| cfg_base | input | 24 | Physical start address of the segment |
| cfg_limit | input | 16 | Segment length in bytes |
| cfg_flags | input | 4 | {present, read, write, execute} |
| cfg_len | input | 5 | New bound register value |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 3 | 0 none, 1 range, 2 absent, 3 bounds, 4 rights |
| rsp_paddr | output | 24 | Translated physical address, 0 on a fault |

## Verification
The bench goes after the boundary edges. These are an offset one below the length and one equal to it, a zero-length segment, a segment number equal to the bound, and a sum that carries past 24 bits. A design that compared with the wrong inequality would pass the last byte or leak one byte past the end. A design that kept a carry bit would report a wrong address. The bench also stacks failing conditions on one request to expose a wrong precedence, which shows up as the wrong cause code. It issues a write and a request in the same cycle to catch a table that forwards writes early. It exercises each access kind against each missing right, including the reserved kind, so that a swapped permission bit shows up as a false pass or a false fault.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_RANGE  = 3'd1,
    CAUSE_ABSENT = 3'd2,
    CAUSE_BOUNDS = 3'd3,
    CAUSE_RIGHTS = 3'd4
  } xl_cause_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } xl_kind_e;

  typedef struct packed {
    logic present;
    logic can_rd;
    logic can_wr;
    logic can_ex;
  } xl_flags_t;

  // Does the access kind have the matching right in the descriptor?
  function automatic logic rights_allow(input logic [1:0] kind, input xl_flags_t fl);
    logic ok;
    case (kind)
      KIND_READ:  ok = fl.can_rd;
      KIND_WRITE: ok = fl.can_wr;
      KIND_EXEC:  ok = fl.can_ex;
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int OFF_W   = 16,
  parameter int PADDR_W = 24,
  localparam int DEPTH  = 1 << SEG_W,
  localparam int LEN_W  = SEG_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_bound,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [PADDR_W-1:0] wr_base,
  input  logic [OFF_W-1:0]   wr_limit,
  input  xl_flags_t          wr_flags,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [SEG_W-1:0]   rd_idx,
  output logic [PADDR_W-1:0] rd_base,
  output logic [OFF_W-1:0]   rd_limit,
  output xl_flags_t          rd_flags,
  output logic [LEN_W-1:0]   bound_q
);

  logic [PADDR_W-1:0] base_q  [DEPTH];
  logic [OFF_W-1:0]   limit_q [DEPTH];
  xl_flags_t          flags_q [DEPTH];

  // One register slot per descriptor.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && !wr_bound && (wr_idx == SEG_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        flags_q[i] <= '0;
      end else if (hit) begin
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
        flags_q[i] <= wr_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bound_q <= '0;
    else if (wr_en && wr_bound) bound_q <= wr_len;
  end

  // The read port shows the registered contents, so a write in this cycle is not visible yet.
  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_flags = flags_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int OFF_W   = 16,
  parameter int PADDR_W = 24,
  localparam int LEN_W  = SEG_W + 1
) (
  input  logic [SEG_W-1:0]   seg,
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         kind,
  input  logic [LEN_W-1:0]   bound,
  input  logic [PADDR_W-1:0] base,
  input  logic [OFF_W-1:0]   limit,
  input  xl_flags_t          flags,
  output logic               seg_in_range,
  output logic               entry_present,
  output logic               off_in_limit,
  output logic               rights_ok,
  output xl_cause_e          cause,
  output logic [PADDR_W-1:0] paddr
);

  // The sum wraps at the physical address width.
  function automatic logic [PADDR_W-1:0] relocate(input logic [PADDR_W-1:0] b,
                                                  input logic [OFF_W-1:0] o);
    return b + PADDR_W'(o);
  endfunction

  assign seg_in_range  = {1'b0, seg} < bound;
  assign entry_present = flags.present;
  assign off_in_limit  = off < limit;
  assign rights_ok     = rights_allow(kind, flags);

  // The cause follows a fixed precedence.
  always_comb begin
    if (!seg_in_range)       cause = CAUSE_RANGE;
    else if (!entry_present) cause = CAUSE_ABSENT;
    else if (!off_in_limit)  cause = CAUSE_BOUNDS;
    else if (!rights_ok)     cause = CAUSE_RIGHTS;
    else                     cause = CAUSE_NONE;
  end

  assign paddr = (cause == CAUSE_NONE) ? relocate(base, off) : '0;

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int OFF_W   = 16,
  parameter int PADDR_W = 24,
  localparam int LEN_W  = SEG_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [SEG_W-1:0]   cfg_idx,
  input  logic [PADDR_W-1:0] cfg_base,
  input  logic [OFF_W-1:0]   cfg_limit,
  input  logic [3:0]         cfg_flags,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               req_valid,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_kind,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_cause,
  output logic [PADDR_W-1:0] rsp_paddr
);

  logic [PADDR_W-1:0] ent_base;
  logic [OFF_W-1:0]   ent_limit;
  xl_flags_t          ent_flags;
  logic [LEN_W-1:0]   bound_q;

  // Internal check results, brought out as named wires for the checker.
  logic               seg_in_range;
  logic               entry_present;
  logic               off_in_limit;
  logic               rights_ok;
  xl_cause_e          chk_cause;
  logic [PADDR_W-1:0] chk_paddr;

  seg_desc_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_bound (cfg_sel),
    .wr_idx   (cfg_idx),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .wr_flags (xl_flags_t'(cfg_flags)),
    .wr_len   (cfg_len),
    .rd_idx   (req_seg),
    .rd_base  (ent_base),
    .rd_limit (ent_limit),
    .rd_flags (ent_flags),
    .bound_q  (bound_q)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_check (
    .seg           (req_seg),
    .off           (req_off),
    .kind          (req_kind),
    .bound         (bound_q),
    .base          (ent_base),
    .limit         (ent_limit),
    .flags         (ent_flags),
    .seg_in_range  (seg_in_range),
    .entry_present (entry_present),
    .off_in_limit  (off_in_limit),
    .rights_ok     (rights_ok),
    .cause         (chk_cause),
    .paddr         (chk_paddr)
  );

  // Response stage. All outputs stay at zero unless a request was taken.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (chk_cause != CAUSE_NONE);
      rsp_cause <= req_valid ? 3'(chk_cause) : 3'd0;
      rsp_paddr <= req_valid ? chk_paddr : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PADDR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               seg_in_range,
  input logic               entry_present,
  input logic               off_in_limit,
  input logic               rights_ok,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [2:0]         rsp_cause,
  input logic [PADDR_W-1:0] rsp_paddr
);

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && rsp_cause == 3'd0));
  assert_range_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_in_range) |=> (rsp_fault && rsp_cause == 3'd1));
  assert_absent_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_in_range && !entry_present) |=> (rsp_cause == 3'd2));
  assert_bounds_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_in_range && entry_present && !off_in_limit) |=> (rsp_cause == 3'd3));
  assert_rights_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_in_range && entry_present && off_in_limit && !rights_ok)
      |=> (rsp_cause == 3'd4));
  assert_fault_matches_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));
  assert_clean_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_in_range && entry_present && off_in_limit && rights_ok)
      |=> (!rsp_fault && rsp_cause == 3'd0));
  assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0));

endmodule

bind seg_xlate_top seg_xlate_chk #(.PADDR_W(PADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .seg_in_range  (seg_in_range),
  .entry_present (entry_present),
  .off_in_limit  (off_in_limit),
  .rights_ok     (rights_ok),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_cause     (rsp_cause),
  .rsp_paddr     (rsp_paddr)
);

// File: tb/seg_xlate_top_test.sv
module seg_xlate_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [3:0]  cfg_idx;
  logic [23:0] cfg_base;
  logic [15:0] cfg_limit;
  logic [3:0]  cfg_flags;
  logic [4:0]  cfg_len;
  logic        req_valid;
  logic [3:0]  req_seg;
  logic [15:0] req_off;
  logic [1:0]  req_kind;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [23:0] rsp_paddr;

  always #2 clk = ~clk;

  seg_xlate_top uut (.*);

  typedef struct {
    logic        fault;
    logic [2:0]  cause;
    logic [23:0] paddr;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // Bench-side copy of the table, updated only through the write tasks.
  logic [23:0] m_base [16];
  logic [15:0] m_lim  [16];
  logic [3:0]  m_fl   [16];
  logic [4:0]  m_len;

  function automatic exp_t predict(input logic [3:0] s, input logic [15:0] o,
                                   input logic [1:0] k, input string tag);
    exp_t e;
    logic has_right;
    e.tag = tag; e.fault = 1'b1; e.paddr = 24'h0;
    has_right = (k == 2'd0) ? m_fl[s][2] : (k == 2'd1) ? m_fl[s][1] :
                (k == 2'd2) ? m_fl[s][0] : 1'b0;
    if (int'(s) >= int'(m_len))      e.cause = 3'd1;
    else if (!m_fl[s][3])            e.cause = 3'd2;
    else if (int'(o) >= int'(m_lim[s])) e.cause = 3'd3;
    else if (!has_right)             e.cause = 3'd4;
    else begin
      e.cause = 3'd0; e.fault = 1'b0;
      e.paddr = 24'((int'(m_base[s]) + int'(o)) % (1 << 24));
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [3:0] s, input logic [15:0] o,
                        input logic [1:0] k, input string tag);
    req_seg = s; req_off = o; req_kind = k; req_valid = 1'b1;
    expq.push_back(predict(s, o, k, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic put_entry(input logic [3:0] i, input logic [23:0] b,
                           input logic [15:0] l, input logic [3:0] f);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = i; cfg_base = b; cfg_limit = l; cfg_flags = f;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[i] = b; m_lim[i] = l; m_fl[i] = f;
  endtask

  task automatic put_len(input logic [4:0] n);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = n;
    @(negedge clk);
    cfg_we = 1'b0;
    m_len = n;
  endtask

  // Monitor: after each edge, compare the response with the queue head.
  initial begin
    forever begin
      logic pend;
      @(posedge clk);
      pend = req_valid;
      #1;
      if (rst_n) begin
        check(rsp_valid == pend, "R1", "rsp_valid", 32'(rsp_valid), 32'(pend));
        if (rsp_valid && expq.size() != 0) begin
          exp_t e;
          e = expq.pop_front();
          check(rsp_fault == e.fault, e.tag, "fault", 32'(rsp_fault), 32'(e.fault));
          check(rsp_cause == e.cause, e.tag, "cause", 32'(rsp_cause), 32'(e.cause));
          check(rsp_paddr == e.paddr, e.tag, "paddr", 32'(rsp_paddr), 32'(e.paddr));
        end else if (!rsp_valid) begin
          check(!rsp_fault && rsp_cause == 3'd0, "R1", "idle fault/cause",
                {28'(rsp_cause), 3'd0, rsp_fault}, 32'd0);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0;
    cfg_flags = 0; cfg_len = 0; req_valid = 0; req_seg = 0; req_off = 0; req_kind = 0;
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_lim[i] = 0; m_fl[i] = 0; end
    m_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

    do_req(4'd0, 16'd0, 2'd0, "R10");        // bound is 0 after reset -> range
    put_len(5'd16);
    do_req(4'd5, 16'd0, 2'd0, "R10");        // descriptors absent after reset

    put_entry(4'd0, 24'h001000, 16'h0100, 4'b1111);
    put_entry(4'd1, 24'hFFFF00, 16'h0200, 4'b1100);
    put_entry(4'd2, 24'h123456, 16'h0000, 4'b1111);
    put_entry(4'd3, 24'h000000, 16'h0010, 4'b0000);
    put_entry(4'd4, 24'h400000, 16'hFFFF, 4'b1001);
    put_len(5'd4);

    do_req(4'd0, 16'h00FF, 2'd0, "R8");      // last legal byte
    do_req(4'd0, 16'h0100, 2'd0, "R5");      // offset == limit
    do_req(4'd1, 16'h01FF, 2'd0, "R8");      // sum wraps past 24 bits
    do_req(4'd1, 16'h0000, 2'd1, "R6");      // write without right
    do_req(4'd1, 16'h0000, 2'd2, "R6");      // execute without right
    do_req(4'd0, 16'h0000, 2'd3, "R6");      // reserved kind
    do_req(4'd4, 16'h0000, 2'd2, "R3");      // seg == bound
    put_len(5'd5);
    do_req(4'd4, 16'hFFFE, 2'd2, "R8");
    do_req(4'd4, 16'h0001, 2'd0, "R6");      // read without right
    do_req(4'd2, 16'h0000, 2'd0, "R5");      // zero-length segment
    do_req(4'd3, 16'h0040, 2'd1, "R7");      // absent beats bounds and rights
    do_req(4'd9, 16'hFFFF, 2'd3, "R7");      // range beats all
    do_req(4'd1, 16'h0300, 2'd1, "R7");      // bounds beats rights
    do_req(4'd0, 16'h0000, 2'd1, "R8");
    do_req(4'd0, 16'h0001, 2'd2, "R8");

    put_entry(4'd0, 24'h200000, 16'h0100, 4'b1111);
    do_req(4'd0, 16'h0020, 2'd0, "R2");      // new start address takes effect

    // Write and request in the same cycle: the request sees the old bound.
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = 5'd0;
    do_req(4'd0, 16'h0010, 2'd0, "R2");
    cfg_we = 1'b0; m_len = 5'd0;
    do_req(4'd0, 16'h0010, 2'd0, "R2");      // now out of range

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R1", "responses outstanding", 32'(expq.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule